// File: doc/BRIEF.md
# Free-Running Watchdog with Edge-Gated Reset

This block is a watchdog timer that cannot be halted. An 8-bit down-counter is loaded from a preset register. It steps once per time unit, where the unit is either one second or one minute. A one-pulse-per-second strobe from outside the block provides the seconds. The block derives minutes from it with its own prescaler. When the count reaches zero, an event flag is latched. A reset pulse for the system is raised only when that flag goes from clear to set while the reset output gate is open.

Software controls the block through four byte-wide registers, selected by a 2-bit index:

| Index | Register | Meaning |
|---|---|---|
| 0 | preset | Countdown length in units. |
| 1 | time base | Bit 0 set picks seconds; bit 0 clear picks minutes. |
| 2 | output gate | Bit 1 set allows a reset pulse. |
| 3 | status | Bit 0 is the event flag; writing a one to that bit clears it. |

Writing the preset is how software kicks the watchdog. Clearing the gate is how the timer is made harmless, because the countdown itself never stops.

Top module: `wdt_core`

## Requirements
- R1: After reset, the registers read back as follows: preset 1, time base 0x00, output gate 0x00, status 0x00. Both the event output and the reset pulse output are low.
- R2: When time-base bit 0 is 1, the event flag sets on the Nth one-second strobe after a preset write of N, and not earlier.
- R3: When time-base bit 0 is 0, each unit is TICKS_PER_MIN strobes. The event flag sets on strobe N*TICKS_PER_MIN after a preset write of N.
- R4: A preset write reloads the count and restarts the minute prescaler, so the next expiry is measured from that write.
- R5: A preset write of 0 is stored as 1 and reads back as 1.
- R6: Status bit 0 is write-one-to-clear. Writing 0 to bit 0 leaves the flag unchanged. When an expiry and a clear fall in the same cycle, the flag ends up set.
- R7: wdt_rst_o is high for exactly one cycle. That cycle is the first cycle in which the event flag reads 1 after being 0. The pulse happens only if output-gate bit 1 was set before the expiry.
- R8: Setting the output gate while the event flag is already set produces no pulse. Another expiry while the flag is still set also produces no pulse.
- R9: Once the count reaches zero it stays there, and produces no new event, until the preset is written again.
- R10: A change of time base does not reload the count. The remaining units are then counted in the new base, and the free-running prescaler keeps its phase.
- R11: The countdown runs and sets the event flag even when the output gate is closed. In that case no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register index for writes (0 preset, 1 time base, 2 output gate, 3 status) |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register index for reads |
| rd_data | output | 8 | Combinational read data |
| event_o | output | 1 | Current event flag |
| wdt_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The event flag has two sources that can collide in the same cycle: a clear written by software, and the expiry of the counter. The bench loads a preset of 1 in seconds mode and opens the gate. It then asserts the one-second strobe in the same cycle as a status write of 0x01. It judges the result by two things: the flag must still read 1 afterwards, and exactly one reset pulse must appear. A similar collision is between a preset write and a strobe on the final unit; there, the reload must win.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int DATA_W = 8;

   typedef enum logic [1:0] {
      SEL_PRESET = 2'd0,
      SEL_BASE   = 2'd1,
      SEL_OUTEN  = 2'd2,
      SEL_STATUS = 2'd3
   } wdt_sel_e;

   localparam int BASE_SEC_BIT = 0;
   localparam int OUTEN_BIT    = 1;
   localparam int EVENT_BIT    = 0;
endpackage

// File: rtl/wdt_unit_gen.sv
module wdt_unit_gen #(
   parameter int TICKS_PER_MIN = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   input  logic base_sec,
   input  logic restart,
   output logic unit_tick
);
   localparam int PW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;

   generate
      if (TICKS_PER_MIN == 1) begin : g_passthru
         logic unused_restart;
         assign unused_restart = restart ^ base_sec;
         assign unit_tick = sec_tick;
      end else begin : g_prescale
         localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MIN - 1);
         logic [PW-1:0] pre_q;
         logic          min_tick;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pre_q <= '0;
            else if (restart)  pre_q <= '0;
            else if (sec_tick) pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
         end

         assign min_tick  = sec_tick && (pre_q == LAST);
         assign unit_tick = base_sec ? sec_tick : min_tick;

         // R3: prescaler never leaves its range
         p_pre_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pre_q <= LAST);
         // R4: a restart leaves the prescaler at zero
         p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> pre_q == '0);
      end
   endgenerate

   // R3: a unit step always coincides with a one-second strobe
   p_unit_needs_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      unit_tick |-> sec_tick);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             unit_tick,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt_q <= ONE;
      else if (load)                        cnt_q <= load_val;
      else if (unit_tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expire = unit_tick && !load && (cnt_q == ONE);

   // R9: an exhausted count holds until the next load
   p_hold_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load) |=> cnt_q == '0);
   // R2: without a load the count moves by at most one step down
   p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
   // R4: a load always takes effect
   p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val));
   // R9: expiry is reported only on the step that reaches zero
   p_expire_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> cnt_q == '0);
endmodule

// File: rtl/wdt_event_gate.sv
module wdt_event_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clr_req,
   input  logic oe_en,
   output logic event_flag,
   output logic rst_pulse
);
   logic ev_q;
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_q    <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (expire)       ev_q <= 1'b1;
         else if (clr_req) ev_q <= 1'b0;
         pulse_q <= expire && !ev_q && oe_en;
      end
   end

   assign event_flag = ev_q;
   assign rst_pulse  = pulse_q;

   // R7: pulse lasts a single cycle
   p_pulse_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   // R7: pulse only on a 0-to-1 transition of the flag
   p_pulse_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> (ev_q && !$past(ev_q)));
   // R7: pulse only with the gate open at that transition
   p_pulse_needs_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $past(oe_en));
   // R6: expiry beats a simultaneous clear
   p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> ev_q);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
#(
   parameter int CNT_W         = 8,
   parameter int TICKS_PER_MIN = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              event_o,
   output logic              wdt_rst_o
);
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("wdt_core: CNT_W must be between 1 and the register width");
      end
      if (TICKS_PER_MIN < 1) begin : g_bad_ticks
         $error("wdt_core: TICKS_PER_MIN must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0]  preset_q;
   logic [DATA_W-1:0] base_q;
   logic [DATA_W-1:0] outen_q;
   logic [CNT_W-1:0]  wr_cnt;
   logic [CNT_W-1:0]  load_val;
   logic              load;
   logic              clr_req;
   logic              unit_tick;
   logic              expire;
   logic              ev;
   logic              wr_hi_unused;

   assign wr_cnt       = wr_data[CNT_W-1:0];
   assign wr_hi_unused = ^(wr_data >> CNT_W);
   assign load_val     = (wr_cnt == '0) ? ONE : wr_cnt;
   assign load         = wr_en && (wr_sel == SEL_PRESET);
   assign clr_req      = wr_en && (wr_sel == SEL_STATUS) && wr_data[EVENT_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preset_q <= ONE;
         base_q   <= '0;
         outen_q  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_PRESET: preset_q <= load_val;
            SEL_BASE:   base_q   <= wr_data;
            SEL_OUTEN:  outen_q  <= wr_data;
            default:    ;
         endcase
      end
   end

   wdt_unit_gen #(.TICKS_PER_MIN(TICKS_PER_MIN)) u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_tick  (sec_tick),
      .base_sec  (base_q[BASE_SEC_BIT]),
      .restart   (load),
      .unit_tick (unit_tick)
   );

   wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_val  (load_val),
      .unit_tick (unit_tick),
      .expire    (expire)
   );

   wdt_event_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire     (expire),
      .clr_req    (clr_req),
      .oe_en      (outen_q[OUTEN_BIT]),
      .event_flag (ev),
      .rst_pulse  (wdt_rst_o)
   );

   always_comb begin
      unique case (rd_sel)
         SEL_PRESET: rd_data = DATA_W'(preset_q);
         SEL_BASE:   rd_data = base_q;
         SEL_OUTEN:  rd_data = outen_q;
         default:    rd_data = DATA_W'({wr_hi_unused & 1'b0, ev});
      endcase
   end

   assign event_o = ev;

   // R5: the stored preset is never zero
   p_preset_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      preset_q != '0);
   // R11: with the gate closed no reset pulse leaves the block
   p_no_pulse_gate_shut_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(outen_q[OUTEN_BIT]) |-> !wdt_rst_o);
   // R6: a clear with no expiry empties the flag
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !expire) |=> !event_o);
endmodule

// File: tb/tb_wdt_core.sv
module tb_wdt_core;
   localparam int TPM = 60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_sel = 2'd0;
   logic [7:0] rd_data;
   logic       event_o;
   logic       wdt_rst_o;

   int checks = 0;
   int failures = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wdt_core #(.CNT_W(8), .TICKS_PER_MIN(TPM)) dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data),
      .event_o(event_o), .wdt_rst_o(wdt_rst_o)
   );

   always @(posedge clk) if (rst_n && wdt_rst_o) pulses++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'd0;
   endtask

   task automatic rd(input logic [1:0] sel, output int v);
      rd_sel = sel;
      #1;
      v = rd_data;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         sec_tick = 1'b1;
         @(negedge clk);
      end
      sec_tick = 1'b0;
   endtask

   task automatic arm(input logic [7:0] base, input logic [7:0] pre, input logic [7:0] oe);
      wr(2'd2, 8'h00);
      wr(2'd1, base);
      wr(2'd0, pre);
      wr(2'd3, 8'h01);
      wr(2'd2, oe);
   endtask

   task automatic t_reset;
      int v;
      rd(2'd0, v); chk("R1 preset", v, 1);
      rd(2'd1, v); chk("R1 base", v, 0);
      rd(2'd2, v); chk("R1 outen", v, 0);
      rd(2'd3, v); chk("R1 status", v, 0);
      chk("R1 event", event_o, 0);
      chk("R1 pulse", wdt_rst_o, 0);
   endtask

   task automatic t_seconds;
      int p0;
      arm(8'h01, 8'd5, 8'h00);
      p0 = pulses;
      ticks(4); chk("R2 early", event_o, 0);
      ticks(1); chk("R2 expiry", event_o, 1);
      idle(2);  chk("R11 no pulse gate shut", pulses - p0, 0);
   endtask

   task automatic t_minutes;
      arm(8'h00, 8'd2, 8'h00);
      ticks(2 * TPM - 1); chk("R3 early", event_o, 0);
      ticks(1);           chk("R3 expiry", event_o, 1);
   endtask

   task automatic t_kick;
      arm(8'h01, 8'd3, 8'h00);
      ticks(2);
      wr(2'd0, 8'd3);
      ticks(2); chk("R4 kick delays", event_o, 0);
      ticks(1); chk("R4 kick expiry", event_o, 1);
      arm(8'h00, 8'd1, 8'h00);
      ticks(30);
      wr(2'd0, 8'd1);
      ticks(TPM - 1); chk("R4 prescaler restart", event_o, 0);
      ticks(1);       chk("R4 minute expiry", event_o, 1);
   endtask

   task automatic t_zero;
      int v;
      wr(2'd1, 8'h01);
      wr(2'd0, 8'd0);
      rd(2'd0, v); chk("R5 readback", v, 1);
      wr(2'd3, 8'h01);
      ticks(1); chk("R5 one unit", event_o, 1);
   endtask

   task automatic t_w1c;
      int v;
      wr(2'd3, 8'h00); rd(2'd3, v); chk("R6 write zero keeps", v, 1);
      wr(2'd3, 8'hFE); rd(2'd3, v); chk("R6 other bits keep", v, 1);
      wr(2'd3, 8'h01); rd(2'd3, v); chk("R6 w1c clears", v, 0);
   endtask

   task automatic t_pulse;
      int p0;
      arm(8'h01, 8'd2, 8'h02);
      p0 = pulses;
      ticks(1); chk("R7 no early pulse", wdt_rst_o, 0);
      ticks(1);
      chk("R7 pulse with rise", wdt_rst_o, 1);
      chk("R7 flag with pulse", event_o, 1);
      idle(1);
      chk("R7 single cycle", wdt_rst_o, 0);
      chk("R7 pulse count", pulses - p0, 1);
   endtask

   task automatic t_late_oe;
      int p0;
      arm(8'h01, 8'd1, 8'h00);
      p0 = pulses;
      ticks(1); chk("R8 flag set", event_o, 1);
      wr(2'd2, 8'h02);
      idle(3); chk("R8 late gate", pulses - p0, 0);
      wr(2'd0, 8'd1);
      ticks(1); idle(2);
      chk("R8 second expiry", pulses - p0, 0);
      chk("R8 flag still set", event_o, 1);
   endtask

   task automatic t_hold;
      int p0;
      wr(2'd3, 8'h01);
      p0 = pulses;
      ticks(10); idle(1);
      chk("R9 hold no event", event_o, 0);
      chk("R9 hold no pulse", pulses - p0, 0);
      wr(2'd0, 8'd1);
      ticks(1); idle(1);
      chk("R9 rewrite expires", event_o, 1);
      chk("R7 pulse after rewrite", pulses - p0, 1);
   endtask

   task automatic t_base;
      arm(8'h01, 8'd3, 8'h00);
      ticks(1);
      wr(2'd1, 8'h00);
      ticks(TPM - 2 + TPM); chk("R10 not yet", event_o, 0);
      ticks(1);             chk("R10 no reload", event_o, 1);
   endtask

   task automatic t_same_cycle;
      int p0;
      arm(8'h01, 8'd1, 8'h02);
      p0 = pulses;
      sec_tick = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h01;
      @(negedge clk);
      sec_tick = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
      idle(1);
      chk("R6 set beats clear", event_o, 1);
      chk("R7 pulse on collision", pulses - p0, 1);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset;
      t_seconds;
      t_minutes;
      t_kick;
      t_zero;
      t_w1c;
      t_pulse;
      t_late_oe;
      t_hold;
      t_base;
      t_same_cycle;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule